// File: doc/BRIEF.md
# Iterative Multiply Coprocessor

This block sits beside a small processor core on its custom-instruction offload port. When the core meets an instruction it cannot execute itself, it raises a request strobe and holds the 32-bit instruction word and the two source register values on the port. The unit checks whether the word is one of the four integer multiply instructions. If it is, the unit claims the request at once by raising a busy indication. It then forms the product one multiplier bit per clock in a shift-and-add datapath, and returns the result with a one-cycle completion pulse that also tells the core to write the value back.

An instruction that is not a multiply is left alone, so that another coprocessor, or the core's own timeout, can deal with it. The low-word multiply stops after 32 accumulation steps. The three high-word forms need the full 64-bit product, so they run 64 steps. Each of them extends its operands according to its own signedness rule.

Top module: `seq_mul_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, rspWait, rspReady and rspWrite are all low.
- R2: A request is accepted only when bits [6:0] of the instruction equal 0110011, bits [31:25] equal 0000001 and bits [14:12] are one of 000 (low word), 001 (high word, both signed), 010 (high word, first operand signed, second unsigned) or 011 (high word, both unsigned).
- R3: Any other instruction word is ignored: as long as it is held valid, neither rspWait nor rspReady is raised.
- R4: rspWait goes high in the cycle after a request is accepted. It stays high until the cycle before rspReady, and it is low while rspReady is high.
- R5: rspReady and rspWrite pulse together for one cycle. For the low-word form they are high in the 33rd cycle after the accepting clock edge, and for the high-word forms in the 65th.
- R6: The low-word form returns bits [31:0] of the product on rspData.
- R7: Function 001 returns bits [63:32] of the product of the two operands, both taken as signed.
- R8: Function 010 returns bits [63:32] of the product of the first operand taken as signed and the second taken as unsigned.
- R9: Function 011 returns bits [63:32] of the unsigned product.
- R10: After the completion pulse the unit stays idle and does not start again while the request remains valid. A new request is accepted only after reqValid has gone low and then high again.
- R11: A valid supported request never goes 16 consecutive cycles without rspWait or rspReady high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Offload request strobe, held until completion |
| reqInsn | input | 32 | Instruction word being offloaded |
| reqOpA | input | 32 | Value of the first source register |
| reqOpB | input | 32 | Value of the second source register |
| rspWrite | output | 1 | Write-back strobe for rspData |
| rspData | output | 32 | Result word |
| rspWait | output | 1 | Unit has claimed the request and is computing |
| rspReady | output | 1 | Completion pulse |

## Verification
The bench aims at operand signs. It sends the most negative value, all ones, zero and one to each form, because a unit that extended an operand with the wrong rule would return a wrong high word only when a top bit is set. It counts the cycles from acceptance to the completion pulse for both step counts, which would expose a unit that ran 32 steps for a high-word form (wrong high half) or 64 for the low form (late pulse). It holds the request valid after completion to catch a unit that restarts. It also presents divide, add and non-arithmetic words, which a unit with loose decoding would claim.

// File: rtl/mul_pkg.sv
package mul_pkg;

  localparam int INSN_W = 32;
  localparam logic [6:0] OPC_ARITH  = 7'b0110011;
  localparam logic [6:0] F7_MULDIV  = 7'b0000001;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands, clear accumulator
    logic step;      // one shift-and-add iteration
    logic aSigned;   // extend first operand with its sign at load
    logic bSigned;   // extend second operand with its sign at load
    logic takeHigh;  // select upper result word
  } mulStrobes_t;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [6:0]  opcode,
  input  logic [6:0]  funct7,
  input  logic [2:0]  funct3,
  output mulStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNTW = $clog2(2 * XLEN + 1);
  localparam logic [CNTW-1:0] LO_LAST = CNTW'(XLEN - 1);
  localparam logic [CNTW-1:0] HI_LAST = CNTW'(2 * XLEN - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE, ST_HOLD} ctrlState_t;

  ctrlState_t      state, stateNxt;
  logic [CNTW-1:0] stepCnt;
  logic            highSel;
  logic            hit;
  logic            wantHigh;
  logic [CNTW-1:0] lastStep;

  assign hit      = (opcode == OPC_ARITH) && (funct7 == F7_MULDIV) && !funct3[2];
  assign wantHigh = (funct3[1:0] != 2'b00);
  assign lastStep = highSel ? HI_LAST : LO_LAST;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (reqValid && hit) stateNxt = ST_RUN;
      ST_RUN:  if (stepCnt == lastStep) stateNxt = ST_DONE;
      ST_DONE: stateNxt = ST_HOLD;
      ST_HOLD: if (!reqValid) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      highSel <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && reqValid && hit) begin
        stepCnt <= '0;
        highSel <= wantHigh;
      end else if (state == ST_RUN) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load     = (state == ST_IDLE) && reqValid && hit;
    strobes.step     = (state == ST_RUN);
    strobes.aSigned  = (funct3 == 3'b001) || (funct3 == 3'b010);
    strobes.bSigned  = (funct3 == 3'b001);
    strobes.takeHigh = highSel;
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobes_t     strobes,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);

  localparam int PW = 2 * XLEN;

  logic [PW-1:0] mcand;
  logic [PW-1:0] mplier;
  logic [PW-1:0] acc;

  function automatic logic [PW-1:0] extend(input logic [XLEN-1:0] v, input logic sgn);
    return {{XLEN{sgn & v[XLEN-1]}}, v};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
    end else if (strobes.load) begin
      mcand  <= extend(opA, strobes.aSigned);
      mplier <= extend(opB, strobes.bSigned);
      acc    <= '0;
    end else if (strobes.step) begin
      if (mplier[0]) acc <= acc + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

  assign result = strobes.takeHigh ? acc[PW-1:XLEN] : acc[XLEN-1:0];

endmodule

// File: rtl/seq_mul_unit.sv
module seq_mul_unit
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [INSN_W-1:0] reqInsn,
  input  logic [XLEN-1:0]   reqOpA,
  input  logic [XLEN-1:0]   reqOpB,
  output logic              rspWrite,
  output logic [XLEN-1:0]   rspData,
  output logic              rspWait,
  output logic              rspReady
);

  mulStrobes_t strobes;
  logic        busy;
  logic        done;

  mul_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .opcode   (reqInsn[6:0]),
    .funct7   (reqInsn[31:25]),
    .funct3   (reqInsn[14:12]),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  mul_datapath #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (reqOpA),
    .opB     (reqOpB),
    .result  (rspData)
  );

  assign rspWait  = busy;
  assign rspReady = done;
  assign rspWrite = done;

endmodule

// File: rtl/seq_mul_unit_chk.sv
module seq_mul_unit_chk
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [INSN_W-1:0] reqInsn,
  input logic [XLEN-1:0]   reqOpA,
  input logic [XLEN-1:0]   reqOpB,
  input logic              rspWrite,
  input logic [XLEN-1:0]   rspData,
  input logic              rspWait,
  input logic              rspReady
);

  logic       supported;
  logic [4:0] unclaimedCnt;
  logic       served;

  assign supported = (reqInsn[6:0] == OPC_ARITH) && (reqInsn[31:25] == F7_MULDIV)
                     && !reqInsn[14];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unclaimedCnt <= '0;
      served       <= 1'b0;
    end else if (!reqValid) begin
      unclaimedCnt <= '0;
      served       <= 1'b0;
    end else if (rspReady) begin
      served <= 1'b1;
    end else if (supported && !rspWait && !served && unclaimedCnt != 5'd31) begin
      unclaimedCnt <= unclaimedCnt + 1'b1;
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspReady);                                       // R10
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspWait);                                        // R10
  AST_WAIT_UNTIL_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspWait |=> (rspWait || rspReady));                            // R4
  AST_WAIT_OFF_AT_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> !rspWait);                                        // R4
  AST_READY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspReady) |-> $past(rspWait));                           // R4
  AST_WRITE_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspWrite |-> rspReady);                                        // R5
  AST_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !supported && !rspWait && !rspReady) |=> !rspWait); // R3
  AST_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    unclaimedCnt < 5'd16);                                         // R11

endmodule

bind seq_mul_unit seq_mul_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/seq_mul_unit_tb.sv
module seq_mul_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqInsn = '0;
  logic [31:0] reqOpA = '0;
  logic [31:0] reqOpB = '0;
  logic        rspWrite;
  logic [31:0] rspData;
  logic        rspWait;
  logic        rspReady;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;  // 250 MHz

  seq_mul_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqInsn(reqInsn),
    .reqOpA(reqOpA), .reqOpB(reqOpB), .rspWrite(rspWrite), .rspData(rspData),
    .rspWait(rspWait), .rspReady(rspReady)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInsn(input logic [6:0] f7, input logic [2:0] f3,
                                         input logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  // Expected result from the requirement text (R6..R9)
  function automatic logic [31:0] model(input logic [2:0] f3, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [63:0] ea, eb, prod;
    ea = (f3 == 3'b001 || f3 == 3'b010) ? {{32{a[31]}}, a} : {32'd0, a};
    eb = (f3 == 3'b001) ? {{32{b[31]}}, b} : {32'd0, b};
    prod = ea * eb;
    return (f3 == 3'b000) ? prod[31:0] : prod[63:32];
  endfunction

  function automatic string reqOf(input logic [2:0] f3);
    case (f3)
      3'b000: return "R6";
      3'b001: return "R7";
      3'b010: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic runMul(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    int cyc = 0;
    int expLat;
    logic sawReady = 1'b0;
    expLat = (f3 == 3'b000) ? 33 : 65;
    @(negedge clk);
    reqInsn = mkInsn(7'b0000001, f3, 7'b0110011);
    reqOpA = a; reqOpB = b; reqValid = 1'b1;
    while (!sawReady && cyc < 100) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (cyc == 1) check("R4 wait after accept", 64'(rspWait), 64'd1);
      if (rspReady) sawReady = 1'b1;
      else if (!rspWait) check("R11 claim held", 64'(rspWait), 64'd1);
    end
    check("R5 latency", 64'(cyc), 64'(expLat));
    check("R5 write with ready", 64'(rspWrite), 64'd1);
    check("R4 wait low at ready", 64'(rspWait), 64'd0);
    check(reqOf(f3), 64'(rspData), 64'(model(f3, a, b)));
    // R10: keep valid high, unit must stay idle
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check("R10 no restart", 64'({rspWait, rspReady}), 64'd0);
    end
    reqValid = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic runIgnored(input logic [31:0] insn);
    logic seen = 1'b0;
    @(negedge clk);
    reqInsn = insn; reqOpA = 32'h1234; reqOpB = 32'h5678; reqValid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (rspWait || rspReady) seen = 1'b1;
    end
    check("R3 ignored insn", 64'(seen), 64'd0);
    reqValid = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 64'({rspWait, rspReady, rspWrite}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({rspWait, rspReady, rspWrite}), 64'd0);

    // Directed corners (R2, R6..R9)
    for (int f = 0; f < 4; f++) begin
      runMul(3'(f), 32'h8000_0000, 32'h8000_0000);
      runMul(3'(f), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      runMul(3'(f), 32'hFFFF_FFFF, 32'd1);
      runMul(3'(f), 32'd0, 32'h7FFF_FFFF);
      runMul(3'(f), 32'h7FFF_FFFF, 32'h8000_0001);
    end

    // R3: decode rejects near misses
    runIgnored(mkInsn(7'b0000001, 3'b100, 7'b0110011));
    runIgnored(mkInsn(7'b0000001, 3'b111, 7'b0110011));
    runIgnored(mkInsn(7'b0000000, 3'b000, 7'b0110011));
    runIgnored(mkInsn(7'b0000001, 3'b000, 7'b0001011));

    // Random mix
    for (int n = 0; n < 40; n++) begin
      runMul(3'($urandom_range(0, 3)), $urandom, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule